// File: doc/BRIEF.md
# Host Bus Byte-Lane Select Generator

This block takes accesses from inside the chip and turns them into transfers on a 16-bit external host bus. Each access has a size (byte, halfword or word), a byte address, write data and a write flag. The block drives the external address pins and the write data, aligned to the correct lanes. It also drives two optional active-low lane strobes. Word accesses do not fit on the bus in one transfer, so the block splits each one into two halfword transfers on consecutive cycles and merges the two read halves into one response.

A configuration input chooses between two modes. With lane strobes enabled, any byte can be read or written correctly, but the two highest address pins are given up for the strobes. With lane strobes disabled, every address pin carries the halfword index, so the reachable space is twice as large. In that mode byte accesses are unsafe: an odd byte address acts on the even byte, and a byte write also overwrites its neighbour. The block raises a status flag on every such byte transfer so that the system can detect the corruption. Chip-select decoding and wait-state timing belong to other blocks.

Top module: `hb_lane_gen`

## Requirements
- R1: With strobes enabled, a byte transfer drives exactly one strobe low: `hb_bsel_n[0]` for an even byte address (bit 0 = 0, low lane bits 7:0) and `hb_bsel_n[1]` for an odd one (high lane bits 15:8).
- R2: With strobes enabled, halfword and word transfers drive both strobes low (`hb_bsel_n` = 2'b00). With strobes disabled, and whenever no transfer is active, both strobes stay high (2'b11).
- R3: With strobes enabled, the low `PIN_W-2` address pins carry the halfword index (byte address shifted right by one), and the top two pins are driven 0.
- R4: With strobes disabled, all `PIN_W` address pins carry the halfword index. The index is truncated to the pin width.
- R5: A word access (size 2) produces two transfers on consecutive cycles: the lower half at halfword index n, then the upper half at n+1, wrapping within the internal index width. `req_ready` is low during the first transfer.
- R6: Write lane data: a byte write puts the byte on both lanes, a halfword write puts data bits 15:0 on the bus, and a word write sends bits 15:0 and then bits 31:16.
- R7: Byte read data is zero-extended to 32 bits. It is taken from the lane chosen by address bit 0 when strobes are enabled, and always from the low lane when strobes are disabled. Halfword reads are zero-extended.
- R8: `byte_hazard` is high exactly during byte transfers (size 0) made with strobes disabled, and is low otherwise.
- R9: A read response (`rsp_valid`) appears in the cycle of the last transfer of a read and never for writes. For a word read it is {second halfword, first halfword}.
- R10: After reset, no transfer is active, both strobes are high, `req_ready` is high and `rsp_valid` is low.
- R11: An accepted request appears on the bus in the cycle after the clock edge that accepted it. Size encoding: 0 = byte, 1 = halfword, 2 = word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bsel_en | input | 1 | 1 enables the lane strobes |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request will be accepted at this edge |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | ADDR_W | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data (right-aligned) |
| rsp_valid | output | 1 | Read result valid |
| rsp_rdata | output | 32 | Read result, zero-extended |
| hb_valid | output | 1 | Bus transfer active |
| hb_write | output | 1 | Bus transfer is a write |
| hb_addr | output | PIN_W | External address pins |
| hb_bsel_n | output | 2 | Active-low lane strobes, bit 0 low lane |
| hb_wdata | output | 16 | Lane-aligned write data |
| hb_rdata | input | 16 | Bus read data, same cycle as transfer |
| byte_hazard | output | 1 | Byte transfer without strobes |

## Verification
The bench sweeps both modes, all three sizes, reads and writes, and a spread of addresses. The address set includes odd bytes, indexes above the narrower strobe-mode pin range, and a word at the very top of the space whose second half wraps to index zero. A design that picks the wrong lane from address bit 0 asserts the wrong strobe or returns the neighbour byte. A design that forgets to give up the two pins in strobe mode puts stray high bits on the address pins. A sequencer that loses the increment, or swaps the halves, repeats the first address or returns the word with its halves reversed. The bench also checks that the hazard flag follows exactly the strobe-less byte cases and no others.

// File: rtl/hb_lane_pkg.sv
package hb_lane_pkg;
   localparam int LANE_W = 16;
   localparam int WORD_W = 2 * LANE_W;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } hb_size_e;
endpackage

// File: rtl/hb_xfer_seq.sv
module hb_xfer_seq
   import hb_lane_pkg::*;
#(
   parameter int ADDR_W = 32,
   localparam int HW_W = ADDR_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_size,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic [WORD_W-1:0] req_wdata,
   input  logic [LANE_W-1:0] lo_in,
   output logic              req_ready,
   output logic              x_valid,
   output logic [1:0]        x_size,
   output logic [HW_W-1:0]   x_hw,
   output logic              x_a0,
   output logic              x_write,
   output logic [WORD_W-1:0] x_wdata,
   output logic              x_phase,
   output logic              x_last,
   output logic [LANE_W-1:0] lo_q
);
   logic first_of_word;

   assign first_of_word = x_valid && (x_size == SZ_WORD) && !x_phase;
   assign req_ready     = !first_of_word;
   assign x_last        = (x_size != SZ_WORD) || x_phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_valid <= 1'b0;
         x_size  <= SZ_BYTE;
         x_hw    <= '0;
         x_a0    <= 1'b0;
         x_write <= 1'b0;
         x_wdata <= '0;
         x_phase <= 1'b0;
         lo_q    <= '0;
      end else if (req_ready) begin
         x_valid <= req_valid;
         x_phase <= 1'b0;
         if (req_valid) begin
            x_size  <= req_size;
            x_hw    <= req_addr[ADDR_W-1:1];
            x_a0    <= req_addr[0];
            x_write <= req_write;
            x_wdata <= req_wdata;
         end
      end else begin
         x_phase <= 1'b1;
         x_hw    <= x_hw + 1'b1;
         lo_q    <= lo_in;
      end
   end

   a_r5_ready_low_mid_word: assert property (@(posedge clk) disable iff (!rst_n)
      (x_valid && x_size == SZ_WORD && !x_phase) |-> !req_ready);
   a_r5_second_half_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (x_valid && x_size == SZ_WORD && !x_phase) |=> (x_valid && x_phase));
   a_r5_index_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (x_valid && x_phase) |-> (x_hw == $past(x_hw) + 1'b1));
endmodule

// File: rtl/hb_addr_map.sv
module hb_addr_map #(
   parameter int PIN_W = 28,
   parameter int HW_W  = 31,
   parameter bit BSEL_CAPABLE = 1'b1,
   localparam int NARROW_W = PIN_W - 2
) (
   input  logic [HW_W-1:0]  hw,
   input  logic             bsel_en,
   output logic [PIN_W-1:0] pins
);
   if (HW_W < PIN_W) begin : g_bad_width
      $error("hb_addr_map: halfword index narrower than pin count");
   end

   logic [PIN_W-1:0] wide;
   logic [PIN_W-1:0] narrow;

   assign wide   = hw[PIN_W-1:0];
   assign narrow = {2'b00, hw[NARROW_W-1:0]};

   if (HW_W > PIN_W) begin : g_trunc
      logic unused_hi;
      assign unused_hi = ^hw[HW_W-1:PIN_W];
   end

   if (BSEL_CAPABLE) begin : g_two_modes
      assign pins = bsel_en ? narrow : wide;
   end else begin : g_wide_only
      logic unused_en;
      assign unused_en = bsel_en;
      assign pins = wide;
   end
endmodule

// File: rtl/hb_lane_steer.sv
module hb_lane_steer
   import hb_lane_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bsel_en,
   input  logic              valid,
   input  logic [1:0]        size,
   input  logic              a0,
   input  logic              phase,
   input  logic [WORD_W-1:0] wdata,
   input  logic [LANE_W-1:0] rdata,
   input  logic [LANE_W-1:0] lo_q,
   output logic [1:0]        bsel_n,
   output logic [LANE_W-1:0] lane_wdata,
   output logic [WORD_W-1:0] rsp_data,
   output logic              hazard
);
   logic       is_byte;
   logic       take_hi;
   logic [7:0] rd_byte;

   assign is_byte = (size == SZ_BYTE);
   assign take_hi = bsel_en && a0;
   assign rd_byte = take_hi ? rdata[15:8] : rdata[7:0];
   assign hazard  = valid && is_byte && !bsel_en;

   always_comb begin
      bsel_n = 2'b11;
      if (valid && bsel_en) begin
         if (is_byte) bsel_n = a0 ? 2'b01 : 2'b10;
         else         bsel_n = 2'b00;
      end
   end

   always_comb begin
      case (size)
         SZ_BYTE: lane_wdata = {wdata[7:0], wdata[7:0]};
         SZ_WORD: lane_wdata = phase ? wdata[31:16] : wdata[15:0];
         default: lane_wdata = wdata[15:0];
      endcase
   end

   always_comb begin
      case (size)
         SZ_BYTE: rsp_data = {24'd0, rd_byte};
         SZ_WORD: rsp_data = {rdata, lo_q};
         default: rsp_data = {16'd0, rdata};
      endcase
   end

   a_r1_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && is_byte && bsel_en) |-> ($countones(~bsel_n) == 1));
   a_r2_idle_strobes_high: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid || !bsel_en) |-> (bsel_n == 2'b11));
   a_r8_hazard_scope: assert property (@(posedge clk) disable iff (!rst_n)
      hazard |-> (valid && !bsel_en && bsel_n == 2'b11));
endmodule

// File: rtl/hb_lane_gen.sv
module hb_lane_gen
   import hb_lane_pkg::*;
#(
   parameter int PIN_W  = 28,
   parameter int ADDR_W = 32,
   parameter bit BSEL_CAPABLE = 1'b1,
   localparam int HW_W = ADDR_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_bsel_en,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_size,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic [31:0]       req_wdata,
   output logic              rsp_valid,
   output logic [31:0]       rsp_rdata,
   output logic              hb_valid,
   output logic              hb_write,
   output logic [PIN_W-1:0]  hb_addr,
   output logic [1:0]        hb_bsel_n,
   output logic [15:0]       hb_wdata,
   input  logic [15:0]       hb_rdata,
   output logic              byte_hazard
);
   if (PIN_W < 4) begin : g_bad_pins
      $error("hb_lane_gen: PIN_W must be at least 4");
   end
   if (ADDR_W < PIN_W + 1) begin : g_bad_addr
      $error("hb_lane_gen: ADDR_W must exceed PIN_W");
   end

   logic              en_eff;
   logic              x_valid, x_a0, x_write, x_phase, x_last;
   logic [1:0]        x_size;
   logic [HW_W-1:0]   x_hw;
   logic [WORD_W-1:0] x_wdata;
   logic [LANE_W-1:0] lo_q;

   if (BSEL_CAPABLE) begin : g_en_live
      assign en_eff = cfg_bsel_en;
   end else begin : g_en_off
      logic unused_cfg;
      assign unused_cfg = cfg_bsel_en;
      assign en_eff = 1'b0;
   end

   hb_xfer_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_size(req_size), .req_addr(req_addr),
      .req_write(req_write), .req_wdata(req_wdata), .lo_in(hb_rdata),
      .req_ready(req_ready), .x_valid(x_valid), .x_size(x_size),
      .x_hw(x_hw), .x_a0(x_a0), .x_write(x_write), .x_wdata(x_wdata),
      .x_phase(x_phase), .x_last(x_last), .lo_q(lo_q)
   );

   hb_addr_map #(.PIN_W(PIN_W), .HW_W(HW_W), .BSEL_CAPABLE(BSEL_CAPABLE)) u_map (
      .hw(x_hw), .bsel_en(en_eff), .pins(hb_addr)
   );

   hb_lane_steer u_steer (
      .clk(clk), .rst_n(rst_n), .bsel_en(en_eff), .valid(x_valid),
      .size(x_size), .a0(x_a0), .phase(x_phase), .wdata(x_wdata),
      .rdata(hb_rdata), .lo_q(lo_q), .bsel_n(hb_bsel_n),
      .lane_wdata(hb_wdata), .rsp_data(rsp_rdata), .hazard(byte_hazard)
   );

   assign hb_valid  = x_valid;
   assign hb_write  = x_valid && x_write;
   assign rsp_valid = x_valid && !x_write && x_last;

   a_r9_no_write_response: assert property (@(posedge clk) disable iff (!rst_n)
      hb_write |-> !rsp_valid);
   a_r3_top_pins_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (hb_valid && en_eff) |-> (hb_addr[PIN_W-1 -: 2] == 2'b00));
endmodule

// File: tb/test_hb_lane_gen.sv
module test_hb_lane_gen;
   localparam int PIN_W  = 8;
   localparam int ADDR_W = 12;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_bsel_en = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic [1:0]        req_size = 2'd0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic              req_write = 1'b0;
   logic [31:0]       req_wdata = '0;
   logic              rsp_valid;
   logic [31:0]       rsp_rdata;
   logic              hb_valid, hb_write, byte_hazard;
   logic [PIN_W-1:0]  hb_addr;
   logic [1:0]        hb_bsel_n;
   logic [15:0]       hb_wdata;
   logic [15:0]       hb_rdata;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   function automatic logic [15:0] mem_at(input logic [PIN_W-1:0] a);
      return {a ^ 8'h5A, a + 8'h33};
   endfunction

   assign hb_rdata = mem_at(hb_addr);

   hb_lane_gen #(.PIN_W(PIN_W), .ADDR_W(ADDR_W)) i_hb_lane_gen (
      .clk(clk), .rst_n(rst_n), .cfg_bsel_en(cfg_bsel_en),
      .req_valid(req_valid), .req_ready(req_ready), .req_size(req_size),
      .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .hb_valid(hb_valid),
      .hb_write(hb_write), .hb_addr(hb_addr), .hb_bsel_n(hb_bsel_n),
      .hb_wdata(hb_wdata), .hb_rdata(hb_rdata), .byte_hazard(byte_hazard)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   function automatic logic [PIN_W-1:0] pins_for(input bit en, input logic [ADDR_W-2:0] h);
      return en ? {2'b00, h[PIN_W-3:0]} : h[PIN_W-1:0];
   endfunction

   task automatic access(input bit en, input logic [1:0] sz, input logic [ADDR_W-1:0] a,
                         input bit wr, input logic [31:0] wd);
      logic [ADDR_W-2:0] h0, h1;
      logic [PIN_W-1:0]  p0, p1;
      logic [1:0]        exp_sel;
      logic [15:0]       r0, r1;
      logic [7:0]        rb;
      h0 = a[ADDR_W-1:1];
      h1 = h0 + 1'b1;
      p0 = pins_for(en, h0);
      p1 = pins_for(en, h1);
      r0 = mem_at(p0);
      r1 = mem_at(p1);
      if (sz == 2'd0) exp_sel = en ? (a[0] ? 2'b01 : 2'b10) : 2'b11;
      else            exp_sel = en ? 2'b00 : 2'b11;
      cfg_bsel_en = en;
      req_valid = 1'b1; req_size = sz; req_addr = a; req_write = wr; req_wdata = wd;
      chk("R10 ready before request", {31'd0, req_ready}, 32'd1);
      @(posedge clk); #1;
      req_valid = 1'b0;
      chk("R11 transfer visible", {31'd0, hb_valid}, 32'd1);
      chk("R11 write flag", {31'd0, hb_write}, {31'd0, wr});
      chk(en ? "R3 address pins" : "R4 address pins", {24'd0, hb_addr}, {24'd0, p0});
      chk(sz == 2'd0 ? "R1 byte strobes" : "R2 wide strobes", {30'd0, hb_bsel_n}, {30'd0, exp_sel});
      chk("R8 hazard flag", {31'd0, byte_hazard}, {31'd0, (sz == 2'd0) && !en});
      if (wr) begin
         if (sz == 2'd0) chk("R6 byte lanes", {16'd0, hb_wdata}, {16'd0, wd[7:0], wd[7:0]});
         else            chk("R6 low lanes", {16'd0, hb_wdata}, {16'd0, wd[15:0]});
      end
      if (sz == 2'd2) begin
         chk("R5 ready low mid word", {31'd0, req_ready}, 32'd0);
         chk("R9 no response mid word", {31'd0, rsp_valid}, 32'd0);
         @(posedge clk); #1;
         chk("R5 second transfer", {31'd0, hb_valid}, 32'd1);
         chk("R5 second address", {24'd0, hb_addr}, {24'd0, p1});
         chk("R2 second strobes", {30'd0, hb_bsel_n}, {30'd0, exp_sel});
         if (wr) chk("R6 upper lanes", {16'd0, hb_wdata}, {16'd0, wd[31:16]});
         else    chk("R9 word read", rsp_rdata, {r1, r0});
      end else if (!wr) begin
         if (sz == 2'd0) begin
            rb = (en && a[0]) ? r0[15:8] : r0[7:0];
            chk("R7 byte read", rsp_rdata, {24'd0, rb});
         end else begin
            chk("R7 half read", rsp_rdata, {16'd0, r0});
         end
      end
      chk("R9 response presence", {31'd0, rsp_valid}, {31'd0, !wr});
      chk("R5 ready after last", {31'd0, req_ready}, 32'd1);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R10 no transfer", {31'd0, hb_valid}, 32'd0);
      chk("R10 strobes high", {30'd0, hb_bsel_n}, 32'd3);
      chk("R10 ready", {31'd0, req_ready}, 32'd1);
      chk("R10 no response", {31'd0, rsp_valid}, 32'd0);
      rst_n = 1'b1;
      @(posedge clk); #1;
      for (int en = 0; en < 2; en++)
         for (int sz = 0; sz < 3; sz++)
            for (int wr = 0; wr < 2; wr++)
               for (int ai = 0; ai < 18; ai++) begin
                  logic [ADDR_W-1:0] a;
                  if (ai == 16)      a = 12'hFFE;
                  else if (ai == 17) a = 12'hFFF;
                  else               a = ADDR_W'((ai * 263) ^ (ai & 1));
                  access(en[0], 2'(sz), a, wr[0],
                         32'hA5C3_1E70 ^ (32'(a) * 32'h0101_0101) ^ 32'(sz));
                  @(posedge clk); #1;
                  chk("R2 idle strobes high", {30'd0, hb_bsel_n}, 32'd3);
                  chk("R8 no hazard when idle", {31'd0, byte_hazard}, 32'd0);
               end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got hang expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule